// File: doc/BRIEF.md
# Depth-Stacked Banked Dual-Port Memory

This block is a 4096-word by 36-bit synchronous memory with two independent access ports that share one clock. Storage is split by address range into eight full-width sub-banks of 512 words. Any single access touches only one sub-bank. Each sub-bank is a plain inferred array, so a synthesis flow can map it onto one wide memory primitive and use every data bit, including the ninth bit of each byte lane.

For each port, the upper three address bits are decoded into a one-hot bank enable, and the write strobe is gated by that enable. The read word is taken from the addressed bank by a logic multiplexer placed after the arrays. The multiplexer is steered by a registered copy of the bank index, so its selection lines up with the one-clock read latency. A port whose enable is low keeps both its read data and its steering index. The block is used wherever a large on-chip buffer must pack its memory tightly and can accept one level of multiplexing on the read path.

Top module: `stacked_dpram`

## Requirements
- R1: Each port can write a 36-bit word to any of the 4096 addresses, and either port can later read it back unchanged.
- R2: Address bits [11:9] choose the bank and bits [8:0] choose the word inside it. Addresses with the same low nine bits but different upper bits hold distinct words.
- R3: On each access, a port enables exactly one bank: the one named by its address bits [11:9]. An idle port enables none.
- R4: A write changes only the addressed word. Other words, including the same offset in other banks, keep their contents.
- R5: Read data appears one clock after the enabled access. The output multiplexer uses the bank index registered with that access, and the output does not change before that clock edge.
- R6: While a port's enable is low, its read data holds its last value and its write data is not stored, whatever its address and write strobe.
- R7: A write through a port returns, on that same port, the word the address held before the write (read-first).
- R8: Both ports operate in the same cycle without interfering, provided they do not write the same address.
- R9: Synchronous active-high reset clears both read outputs to zero. Memory contents are not cleared.
- R10: Words at the bank edges (addresses 0, 511, 512, 2047, 2048 and 4095) are stored and read back correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write strobe |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 36 | Port A write word |
| a_rdata | output | 36 | Port A read word |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write strobe |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 36 | Port B write word |
| b_rdata | output | 36 | Port B read word |

## Verification
The assertions check the following on every cycle. Bank enables are one-hot or zero. An idle or reading port raises no bank write strobe. A disabled port's output stays stable. The registered steering index follows the bank bits of the previous enabled access. Stored values themselves cannot be seen by the assertions, so the following are shown only by the bench's scenarios against its own 4096-word model: aliasing across banks, read-first return on a write, two ports working at once, the bank-edge addresses, and the fact that a disabled port stores nothing.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    localparam int WORD_W     = 36;
    localparam int BANK_DEPTH = 512;
    localparam int NUM_BANKS  = 8;
    localparam int OFFS_W     = $clog2(BANK_DEPTH);
    localparam int BANK_W     = $clog2(NUM_BANKS);
    localparam int ADDR_W     = OFFS_W + BANK_W;

    typedef logic [WORD_W-1:0]    word_t;
    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [OFFS_W-1:0]    offs_t;
    typedef logic [BANK_W-1:0]    bank_idx_t;
    typedef logic [NUM_BANKS-1:0] bank_vec_t;

    typedef struct packed {
        logic  en;
        logic  we;
        addr_t addr;
        word_t wdata;
    } port_req_t;

    typedef struct packed {
        bank_vec_t en;
        bank_vec_t we;
        offs_t     offs;
    } bank_ctl_t;

    function automatic bank_idx_t bank_of(input addr_t a);
        return a[ADDR_W-1:OFFS_W];
    endfunction

    function automatic offs_t offs_of(input addr_t a);
        return a[OFFS_W-1:0];
    endfunction
endpackage

// File: rtl/sdp_bank_decoder.sv
module sdp_bank_decoder
    import sdp_pkg::*;
(
    input  port_req_t req,
    output bank_ctl_t ctl
);
    always_comb begin
        ctl.en   = '0;
        ctl.we   = '0;
        ctl.offs = offs_of(req.addr);
        if (req.en) begin
            ctl.en[bank_of(req.addr)] = 1'b1;
            ctl.we[bank_of(req.addr)] = req.we;
        end
    end
endmodule

// File: rtl/sdp_bank.sv
module sdp_bank
    import sdp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a_en,
    input  logic  a_we,
    input  offs_t a_offs,
    input  word_t a_wdata,
    output word_t a_q,
    input  logic  b_en,
    input  logic  b_we,
    input  offs_t b_offs,
    input  word_t b_wdata,
    output word_t b_q
);
    word_t mem [BANK_DEPTH];

    always_ff @(posedge clk) begin
        if (a_en && a_we) mem[a_offs] <= a_wdata;
        if (b_en && b_we) mem[b_offs] <= b_wdata;
    end

    // Read registers sample the array before this edge's writes land (read-first)
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (a_en) a_q <= mem[a_offs];
            if (b_en) b_q <= mem[b_offs];
        end
    end
endmodule

// File: rtl/sdp_read_sel.sv
module sdp_read_sel
    import sdp_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          en,
    input  bank_idx_t                     idx,
    input  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_q,
    output bank_idx_t                     sel_q,
    output word_t                         rdata
);
    always_ff @(posedge clk) begin
        if (rst)     sel_q <= '0;
        else if (en) sel_q <= idx;
    end

    assign rdata = bank_q[sel_q];
endmodule

// File: rtl/stacked_dpram.sv
module stacked_dpram
    import sdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        a_en,
    input  logic        a_we,
    input  logic [11:0] a_addr,
    input  logic [35:0] a_wdata,
    output logic [35:0] a_rdata,
    input  logic        b_en,
    input  logic        b_we,
    input  logic [11:0] b_addr,
    input  logic [35:0] b_wdata,
    output logic [35:0] b_rdata
);
    port_req_t a_req, b_req;
    bank_ctl_t a_ctl, b_ctl;
    bank_vec_t a_bank_en, a_bank_we, b_bank_en, b_bank_we;
    bank_idx_t a_sel_q, b_sel_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0] a_bank_q, b_bank_q;

    assign a_req = '{en: a_en, we: a_we, addr: a_addr, wdata: a_wdata};
    assign b_req = '{en: b_en, we: b_we, addr: b_addr, wdata: b_wdata};

    sdp_bank_decoder dec_a_i (.req(a_req), .ctl(a_ctl));
    sdp_bank_decoder dec_b_i (.req(b_req), .ctl(b_ctl));

    assign a_bank_en = a_ctl.en;
    assign a_bank_we = a_ctl.we;
    assign b_bank_en = b_ctl.en;
    assign b_bank_we = b_ctl.we;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdp_bank bank_i (
            .clk     (clk),
            .rst     (rst),
            .a_en    (a_bank_en[g]),
            .a_we    (a_bank_we[g]),
            .a_offs  (a_ctl.offs),
            .a_wdata (a_req.wdata),
            .a_q     (a_bank_q[g]),
            .b_en    (b_bank_en[g]),
            .b_we    (b_bank_we[g]),
            .b_offs  (b_ctl.offs),
            .b_wdata (b_req.wdata),
            .b_q     (b_bank_q[g])
        );
    end

    sdp_read_sel sel_a_i (
        .clk(clk), .rst(rst), .en(a_en), .idx(bank_of(a_addr)),
        .bank_q(a_bank_q), .sel_q(a_sel_q), .rdata(a_rdata)
    );
    sdp_read_sel sel_b_i (
        .clk(clk), .rst(rst), .en(b_en), .idx(bank_of(b_addr)),
        .bank_q(b_bank_q), .sel_q(b_sel_q), .rdata(b_rdata)
    );
endmodule

// File: rtl/stacked_dpram_checker.sv
module stacked_dpram_checker
    import sdp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        a_en,
    input logic        a_we,
    input logic [11:0] a_addr,
    input logic [35:0] a_rdata,
    input bank_vec_t   a_bank_en,
    input bank_vec_t   a_bank_we,
    input bank_idx_t   a_sel_q,
    input logic        b_en,
    input logic        b_we,
    input logic [11:0] b_addr,
    input logic [35:0] b_rdata,
    input bank_vec_t   b_bank_en,
    input bank_vec_t   b_bank_we,
    input bank_idx_t   b_sel_q
);
    assert_single_bank_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(a_bank_en) && $onehot0(b_bank_en));
    assert_idle_a_R3: assert property (@(posedge clk) disable iff (rst)
        !a_en |-> a_bank_en == '0);
    assert_idle_b_R3: assert property (@(posedge clk) disable iff (rst)
        !b_en |-> b_bank_en == '0);
    assert_wr_gate_a_R4: assert property (@(posedge clk) disable iff (rst)
        !(a_en && a_we) |-> a_bank_we == '0);
    assert_wr_gate_b_R4: assert property (@(posedge clk) disable iff (rst)
        !(b_en && b_we) |-> b_bank_we == '0);
    assert_hold_a_R6: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> $stable(a_rdata));
    assert_hold_b_R6: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> $stable(b_rdata));
    assert_sel_track_a_R5: assert property (@(posedge clk) disable iff (rst)
        a_en |=> a_sel_q == $past(a_addr[11:9]));
    assert_sel_track_b_R5: assert property (@(posedge clk) disable iff (rst)
        b_en |=> b_sel_q == $past(b_addr[11:9]));
endmodule

bind stacked_dpram stacked_dpram_checker chk_i (
    .clk(clk), .rst(rst),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_rdata(a_rdata),
    .a_bank_en(a_bank_en), .a_bank_we(a_bank_we), .a_sel_q(a_sel_q),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_rdata(b_rdata),
    .b_bank_en(b_bank_en), .b_bank_we(b_bank_we), .b_sel_q(b_sel_q)
);

// File: tb/stacked_dpram_tb_top.sv
module stacked_dpram_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        a_en = 1'b0, a_we = 1'b0, b_en = 1'b0, b_we = 1'b0;
    logic [11:0] a_addr = '0, b_addr = '0;
    logic [35:0] a_wdata = '0, b_wdata = '0;
    logic [35:0] a_rdata, b_rdata;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    logic [35:0] mdl [4096];
    bit          vld [4096];

    always #10 clk = ~clk;   // 50 MHz

    stacked_dpram dut_i (
        .clk(clk), .rst(rst),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    // {a_we, a_addr, a_wdata, b_we, b_addr, b_wdata}; both ports enabled
    localparam int NV = 14;
    localparam logic [97:0] VEC [NV] = '{
        {1'b1, 12'h000, 36'h1_0000_0001, 1'b1, 12'hFFF, 36'hF_FFFF_FFFF},
        {1'b1, 12'h1FF, 36'hA_5A5A_5A5A, 1'b1, 12'h200, 36'h5_A5A5_A5A5},
        {1'b0, 12'h000, 36'h0,           1'b0, 12'hFFF, 36'h0},
        {1'b0, 12'h200, 36'h0,           1'b0, 12'h1FF, 36'h0},
        {1'b1, 12'h400, 36'h0_1234_5678, 1'b0, 12'h000, 36'h0},
        {1'b0, 12'h400, 36'h0,           1'b1, 12'hE00, 36'h8_0000_0000},
        {1'b0, 12'hE00, 36'h0,           1'b0, 12'h400, 36'h0},
        {1'b0, 12'h000, 36'h0,           1'b0, 12'h1FF, 36'h0},
        {1'b1, 12'h000, 36'h3_3333_3333, 1'b0, 12'hFFF, 36'h0},
        {1'b0, 12'h000, 36'h0,           1'b0, 12'h000, 36'h0},
        {1'b1, 12'h7FF, 36'h7_0F0F_0F0F, 1'b1, 12'h800, 36'h9_F0F0_F0F0},
        {1'b0, 12'h800, 36'h0,           1'b0, 12'h7FF, 36'h0},
        {1'b0, 12'h200, 36'h0,           1'b1, 12'hFFF, 36'h0_0000_00FF},
        {1'b0, 12'hFFF, 36'h0,           1'b0, 12'h200, 36'h0}
    };

    function automatic string tag_of(input int i);
        case (i)
            2, 3:    return "R10";
            4:       return "R2";
            5, 6:    return "R8";
            7:       return "R4";
            8, 12:   return "R7";
            9:       return "R8";
            11:      return "R3";
            13:      return "R1";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input bit ae, input bit awe, input logic [11:0] aa, input logic [35:0] ad,
                        input bit be, input bit bwe, input logic [11:0] ba, input logic [35:0] bd,
                        input string tag);
        logic [35:0] ea, eb;
        bit va, vb;
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
        ea = mdl[aa]; va = ae && vld[aa];
        eb = mdl[ba]; vb = be && vld[ba];
        if (ae && awe) begin mdl[aa] = ad; vld[aa] = 1'b1; end
        if (be && bwe) begin mdl[ba] = bd; vld[ba] = 1'b1; end
        @(posedge clk);
        @(negedge clk);
        if (va) check(tag, "port A", a_rdata, ea);
        if (vb) check(tag, "port B", b_rdata, eb);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [35:0] held;
        for (int i = 0; i < 4096; i++) vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R9", "A after reset", a_rdata, 36'h0);
        check("R9", "B after reset", b_rdata, 36'h0);

        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][97], VEC[i][96:85], VEC[i][84:49],
                 1'b1, VEC[i][48], VEC[i][47:36], VEC[i][35:0], tag_of(i));
        end

        // R6: disabled port ignores write strobe and address, output holds
        step(1'b1, 1'b0, 12'h000, 36'h0, 1'b0, 1'b0, 12'h000, 36'h0, "R6");
        held = a_rdata;
        a_en = 1'b0; a_we = 1'b1; a_addr = 12'h400; a_wdata = 36'hD_EADB_EEF0;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); @(negedge clk);
            check("R6", "A hold while idle", a_rdata, held);
            a_addr = a_addr + 12'h201;
        end
        step(1'b1, 1'b0, 12'h400, 36'h0, 1'b0, 1'b0, 12'h000, 36'h0, "R6");

        // R5: output unchanged before the edge, updated after it
        held = a_rdata;
        a_en = 1'b1; a_we = 1'b0; a_addr = 12'h1FF;
        #5;
        check("R5", "A before edge", a_rdata, held);
        @(posedge clk); @(negedge clk);
        check("R5", "A after edge", a_rdata, mdl[12'h1FF]);

        // R9: mid-run reset clears outputs
        a_en = 1'b0; b_en = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        check("R9", "A after mid reset", a_rdata, 36'h0);
        check("R9", "B after mid reset", b_rdata, 36'h0);

        // R9: contents survive reset; R10 bank edge 2048 via port B
        step(1'b1, 1'b0, 12'h7FF, 36'h0, 1'b1, 1'b0, 12'h800, 36'h0, "R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule